// File: doc/BRIEF.md
# UART Transmit Frame Checker

This block sits passively on the serial transmit line of a design under test. It recovers one byte from each frame and scores that byte against an in-order list of expected values. The stimulus side posts each expected byte through a one-cycle valid/data strobe once it has finished delivering the matching input. The checker assembles a byte from eight data samples taken at a fixed interval after the falling start level. It then confirms that the frame ends on a high level and compares the byte with the oldest queued value.

Each outcome appears as its own one-cycle pulse: a good compare, a data mismatch, a byte that arrived with nothing queued, and a bad stop level. Every outcome comes with the received byte, and a compare also carries the expected byte. The cycle count between samples is an input, so the same checker follows a base rate of 15 cycles per bit or any other rate. A control input makes the first serial bit land in the most significant position instead of the least. Four saturating counters record how often the first and last data bits of a frame were zero or one.

Top module: `uart_tx_frame_checker`

## Requirements
- R1: While `rst_n` is low and until it has been high for two rising clock edges, no frame is searched for and every output is 0. After that, a line held high produces no pulse.
- R2: In the idle state, a low level on `line_i` at a rising edge starts a frame. The line is then sampled at that edge plus k·G for k = 1..8 (data bits) and k = 9 (stop bit), where G is `sample_gap_i`.
- R3: `sample_gap_i` gives G in clock cycles, from 1 to 255. The base rate uses 15. Any G in range gives the same decoded byte for the same serial pattern.
- R4: With `msb_first_i` = 0, the first data sample becomes bit 0 of the byte. With `msb_first_i` = 1, the first data sample becomes bit 7 and the eighth becomes bit 0.
- R5: A stop sample of 0 pulses `stop_err_o`, and no compare takes place. The expected queue is left as it was.
- R6: A good frame that arrives while the expected queue is empty pulses `orphan_err_o`, with the byte on `rx_byte_o`.
- R7: A good frame equal to the oldest queued byte pulses `pass_o` and removes that entry. `rx_byte_o` and `exp_byte_o` show the byte.
- R8: A good frame that differs from the oldest queued byte pulses `mismatch_err_o`, with the received byte on `rx_byte_o` and the expected byte on `exp_byte_o`. The entry is still removed.
- R9: Exactly one of the four result pulses appears per frame. It is high for one cycle, starting one cycle after the stop sample. A new start level is accepted from the cycle after the stop sample.
- R10: The queue holds 8 bytes. A push while full is dropped and sets `exp_overflow_o`, which stays set until reset. The exception is a push in the same cycle as a removal, which is accepted.
- R11: A push in the same cycle as a compare is stored after the compare. That compare therefore sees the queue as it stood before the push.
- R12: At every first data sample, `first0_cnt_o` or `first1_cnt_o` (for a sample of 0 or 1) counts up by one, and so do `last0_cnt_o` / `last1_cnt_o` at every eighth sample. This holds whatever the stop level, and the counters saturate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Observed serial transmit line |
| sample_gap_i | input | 8 | Cycles between samples |
| msb_first_i | input | 1 | First serial bit goes to bit 7 when 1 |
| exp_vld_i | input | 1 | Push strobe for an expected byte |
| exp_byte_i | input | 8 | Expected byte to push |
| stop_err_o | output | 1 | Stop level was 0 |
| orphan_err_o | output | 1 | Byte received with empty queue |
| mismatch_err_o | output | 1 | Byte differs from queue head |
| pass_o | output | 1 | Byte matches queue head |
| rx_byte_o | output | 8 | Last received byte |
| exp_byte_o | output | 8 | Queue head used by last compare |
| exp_overflow_o | output | 1 | Sticky dropped-push flag |
| first0_cnt_o | output | 16 | First data bit seen as 0 |
| first1_cnt_o | output | 16 | First data bit seen as 1 |
| last0_cnt_o | output | 16 | Last data bit seen as 0 |
| last1_cnt_o | output | 16 | Last data bit seen as 1 |

## Verification
An expected-byte push and a queue removal by a compare can fall on the same clock edge. The bench forces this by raising the push strobe exactly one cycle after the stop sample. It does so once against an empty queue, where the compare must report an orphan and the pushed byte must then pass on the next frame. It does so again against a full queue, where the push must be kept without setting the overflow flag, so that nine consecutive frames pass. A bench queue model and counts of pulses per frame judge both cases. Random frames with varying sample gaps, bit orders, wrong or missing expected bytes and bad stop levels run against the same model.

// File: rtl/uart_chk_pkg.sv
package uart_chk_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_STOP = 2'd2
  } samp_state_e;

  function automatic logic [BYTE_W-1:0] flip_byte(input logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = v[BYTE_W-1-i];
    return r;
  endfunction

endpackage

// File: rtl/uart_chk_sampler.sv
module uart_chk_sampler
  import uart_chk_pkg::*;
#(
  parameter int unsigned GAP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  input  logic [GAP_W-1:0]  gap_i,
  input  logic              msb_first_i,
  output logic              frame_vld_o,
  output logic              stop_ok_o,
  output logic [BYTE_W-1:0] frame_byte_o,
  output logic              first_hit_o,
  output logic              last_hit_o,
  output logic              bit_o
);

  localparam int unsigned IDX_W = $clog2(BYTE_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

  samp_state_e       state_q, state_d;
  logic [GAP_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              vld_q, vld_d;
  logic              ok_q, ok_d;
  logic              sample;

  // a sample point is reached once the interval counter meets the gap
  assign sample = (state_q != ST_IDLE) && (cnt_q >= gap_i);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    byte_d  = byte_q;
    ok_d    = ok_q;
    vld_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!line_i) begin
          state_d = ST_DATA;
          cnt_d   = GAP_W'(1);
          idx_d   = '0;
        end
      end
      ST_DATA: begin
        if (sample) begin
          sh_d  = {line_i, sh_q[BYTE_W-1:1]};
          cnt_d = GAP_W'(1);
          idx_d = idx_q + 1'b1;
          if (idx_q == LAST_IDX) state_d = ST_STOP;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_STOP: begin
        if (sample) begin
          state_d = ST_IDLE;
          vld_d   = 1'b1;
          ok_d    = line_i;
          byte_d  = msb_first_i ? flip_byte(sh_q) : sh_q;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      byte_q  <= '0;
      vld_q   <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      byte_q  <= byte_d;
      vld_q   <= vld_d;
      ok_q    <= ok_d;
    end
  end

  assign frame_vld_o  = vld_q;
  assign stop_ok_o    = ok_q;
  assign frame_byte_o = byte_q;
  assign first_hit_o  = sample && (state_q == ST_DATA) && (idx_q == '0);
  assign last_hit_o   = sample && (state_q == ST_DATA) && (idx_q == LAST_IDX);
  assign bit_o        = line_i;

endmodule

// File: rtl/uart_chk_expq.sv
module uart_chk_expq #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         ovf_o
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          full, accept, take;

  assign full   = (cnt_q == FULL_CNT);
  assign take   = pop_i && !empty_o;
  assign accept = push_i && (!full || take);

  always_comb begin
    wr_d  = accept ? ((wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1) : wr_q;
    rd_d  = take   ? ((rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1) : rd_q;
    cnt_d = cnt_q;
    if (accept && !take) cnt_d = cnt_q + 1'b1;
    if (!accept && take) cnt_d = cnt_q - 1'b1;
    ovf_d = ovf_q || (push_i && !accept);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem_q[wr_q] <= din_i;
  end

  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rd_q];
  assign ovf_o   = ovf_q;

endmodule

// File: rtl/uart_chk_cov.sv
module uart_chk_cov #(
  parameter int unsigned CW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                first_hit_i,
  input  logic                last_hit_i,
  input  logic                bit_i,
  output logic [3:0][CW-1:0]  cnt_o
);

  logic [3:0] inc;

  // slot order: first=0, first=1, last=0, last=1
  assign inc = {last_hit_i & bit_i, last_hit_i & ~bit_i,
                first_hit_i & bit_i, first_hit_i & ~bit_i};

  for (genvar g = 0; g < 4; g++) begin : g_ctr
    logic [CW-1:0] c_q, c_d;
    always_comb begin
      c_d = c_q;
      if (inc[g] && (c_q != {CW{1'b1}})) c_d = c_q + 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) c_q <= '0;
      else        c_q <= c_d;
    end
    assign cnt_o[g] = c_q;
  end

endmodule

// File: rtl/uart_tx_frame_checker.sv
module uart_tx_frame_checker
  import uart_chk_pkg::*;
#(
  parameter int unsigned GAP_W   = 8,
  parameter int unsigned Q_DEPTH = 8,
  parameter int unsigned CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  input  logic [GAP_W-1:0]  sample_gap_i,
  input  logic              msb_first_i,
  input  logic              exp_vld_i,
  input  logic [BYTE_W-1:0] exp_byte_i,
  output logic              stop_err_o,
  output logic              orphan_err_o,
  output logic              mismatch_err_o,
  output logic              pass_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic [BYTE_W-1:0] exp_byte_o,
  output logic              exp_overflow_o,
  output logic [CNT_W-1:0]  first0_cnt_o,
  output logic [CNT_W-1:0]  first1_cnt_o,
  output logic [CNT_W-1:0]  last0_cnt_o,
  output logic [CNT_W-1:0]  last1_cnt_o
);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              frame_vld, stop_ok, first_hit, last_hit, samp_bit;
  logic [BYTE_W-1:0] frame_byte, head;
  logic              q_empty, q_ovf, do_cmp, do_pop;
  logic [3:0][CNT_W-1:0] cov_cnt;

  uart_chk_sampler #(.GAP_W(GAP_W)) u_samp (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .line_i       (line_i),
    .gap_i        (sample_gap_i),
    .msb_first_i  (msb_first_i),
    .frame_vld_o  (frame_vld),
    .stop_ok_o    (stop_ok),
    .frame_byte_o (frame_byte),
    .first_hit_o  (first_hit),
    .last_hit_o   (last_hit),
    .bit_o        (samp_bit)
  );

  assign do_cmp = frame_vld && stop_ok;
  assign do_pop = do_cmp && !q_empty;

  uart_chk_expq #(.DEPTH(Q_DEPTH), .W(BYTE_W)) u_q (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .push_i  (exp_vld_i),
    .din_i   (exp_byte_i),
    .pop_i   (do_pop),
    .head_o  (head),
    .empty_o (q_empty),
    .ovf_o   (q_ovf)
  );

  uart_chk_cov #(.CW(CNT_W)) u_cov (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .first_hit_i (first_hit),
    .last_hit_i  (last_hit),
    .bit_i       (samp_bit),
    .cnt_o       (cov_cnt)
  );

  // result stage
  logic              stop_err_q, stop_err_d, orphan_q, orphan_d;
  logic              mis_q, mis_d, pass_q, pass_d;
  logic [BYTE_W-1:0] rx_q, rx_d, exp_q, exp_d;

  always_comb begin
    stop_err_d = frame_vld && !stop_ok;
    orphan_d   = do_cmp && q_empty;
    pass_d     = do_pop && (frame_byte == head);
    mis_d      = do_pop && (frame_byte != head);
    rx_d       = frame_vld ? frame_byte : rx_q;
    exp_d      = do_pop ? head : exp_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      stop_err_q <= 1'b0;
      orphan_q   <= 1'b0;
      mis_q      <= 1'b0;
      pass_q     <= 1'b0;
      rx_q       <= '0;
      exp_q      <= '0;
    end else begin
      stop_err_q <= stop_err_d;
      orphan_q   <= orphan_d;
      mis_q      <= mis_d;
      pass_q     <= pass_d;
      rx_q       <= rx_d;
      exp_q      <= exp_d;
    end
  end

  assign stop_err_o     = stop_err_q;
  assign orphan_err_o   = orphan_q;
  assign mismatch_err_o = mis_q;
  assign pass_o         = pass_q;
  assign rx_byte_o      = rx_q;
  assign exp_byte_o     = exp_q;
  assign exp_overflow_o = q_ovf;
  assign first0_cnt_o   = cov_cnt[0];
  assign first1_cnt_o   = cov_cnt[1];
  assign last0_cnt_o    = cov_cnt[2];
  assign last1_cnt_o    = cov_cnt[3];

endmodule

// File: rtl/uart_chk_props.sv
module uart_chk_props #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_err_o,
  input logic             orphan_err_o,
  input logic             mismatch_err_o,
  input logic             pass_o,
  input logic [7:0]       rx_byte_o,
  input logic [7:0]       exp_byte_o,
  input logic             exp_overflow_o,
  input logic [CNT_W-1:0] first0_cnt_o,
  input logic [CNT_W-1:0] last1_cnt_o
);

  a_r9_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stop_err_o, orphan_err_o, mismatch_err_o, pass_o}));

  a_r9_pass_single: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |=> !pass_o);

  a_r9_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_err_o || orphan_err_o || mismatch_err_o) |=>
      !(stop_err_o || orphan_err_o || mismatch_err_o));

  a_r7_pass_equal: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> (rx_byte_o == exp_byte_o));

  a_r8_mismatch_differs: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_err_o |-> (rx_byte_o != exp_byte_o));

  a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    exp_overflow_o |=> exp_overflow_o);

  a_r12_first0_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (first0_cnt_o >= $past(first0_cnt_o)));

  a_r12_last1_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (last1_cnt_o >= $past(last1_cnt_o)));

endmodule

bind uart_tx_frame_checker uart_chk_props #(.CNT_W(CNT_W)) u_props (
  .clk            (clk),
  .rst_n          (rst_n),
  .stop_err_o     (stop_err_o),
  .orphan_err_o   (orphan_err_o),
  .mismatch_err_o (mismatch_err_o),
  .pass_o         (pass_o),
  .rx_byte_o      (rx_byte_o),
  .exp_byte_o     (exp_byte_o),
  .exp_overflow_o (exp_overflow_o),
  .first0_cnt_o   (first0_cnt_o),
  .last1_cnt_o    (last1_cnt_o)
);

// File: tb/sim_uart_tx_frame_checker.sv
module sim_uart_tx_frame_checker;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        line;
  logic [7:0]  gap;
  logic        msb;
  logic        ev;
  logic [7:0]  ed;
  logic        stop_err, orphan, mis, pass, ovf;
  logic [7:0]  rx_b, exp_b;
  logic [15:0] f0, f1, l0, l1;

  always #2.5 clk = ~clk;

  uart_tx_frame_checker u0 (
    .clk(clk), .rst_n(rst_n), .line_i(line), .sample_gap_i(gap),
    .msb_first_i(msb), .exp_vld_i(ev), .exp_byte_i(ed),
    .stop_err_o(stop_err), .orphan_err_o(orphan), .mismatch_err_o(mis),
    .pass_o(pass), .rx_byte_o(rx_b), .exp_byte_o(exp_b),
    .exp_overflow_o(ovf), .first0_cnt_o(f0), .first1_cnt_o(f1),
    .last0_cnt_o(l0), .last1_cnt_o(l1)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // pulse monitor, sampled away from the rising edge
  int m_stop = 0, m_orph = 0, m_mis = 0, m_pass = 0;
  logic [7:0] m_rx, m_exp;
  always @(negedge clk) begin
    if (stop_err) m_stop++;
    if (orphan)   m_orph++;
    if (mis)      m_mis++;
    if (pass)     m_pass++;
    if (stop_err || orphan || mis || pass) begin
      m_rx  = rx_b;
      m_exp = exp_b;
    end
  end

  // bench model
  logic [7:0] mq[$];
  bit         mdl_ovf;
  int         c_f0, c_f1, c_l0, c_l1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; line = 1'b1; ev = 1'b0; ed = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mq.delete();
    mdl_ovf = 1'b0;
    c_f0 = 0; c_f1 = 0; c_l0 = 0; c_l1 = 0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    ev = 1'b1; ed = b;
    @(negedge clk);
    ev = 1'b0;
    if (mq.size() < 8) mq.push_back(b);
    else mdl_ovf = 1'b1;
  endtask

  // bits[0] is the first serial data bit
  task automatic send(input logic [7:0] bits, input bit stop_ok, input int g,
                      input bit ms, input bit cp, input logic [7:0] cpb);
    int s0, s1, s2, s3;
    logic [7:0] rxe;
    s0 = m_stop; s1 = m_orph; s2 = m_mis; s3 = m_pass;
    @(negedge clk);
    gap = 8'(g); msb = ms; line = 1'b0;
    repeat (g) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      line = bits[k];
      repeat (g) @(negedge clk);
    end
    line = stop_ok;
    @(negedge clk);
    line = 1'b1;
    if (cp) begin ev = 1'b1; ed = cpb; end
    @(negedge clk);
    ev = 1'b0;
    repeat (g) @(negedge clk);
    #1;
    rxe = ms ? rev8(bits) : bits;
    if (bits[0]) c_f1++; else c_f0++;
    if (bits[7]) c_l1++; else c_l0++;
    chk((m_stop - s0) + (m_orph - s1) + (m_mis - s2) + (m_pass - s3) == 1,
        "R9 one pulse per frame",
        (m_stop - s0) + (m_orph - s1) + (m_mis - s2) + (m_pass - s3), 1);
    if (!stop_ok) begin
      chk(m_stop - s0 == 1, "R5 stop error", m_stop - s0, 1);
    end else if (mq.size() == 0) begin
      chk(m_orph - s1 == 1, "R6 orphan", m_orph - s1, 1);
      chk(m_rx == rxe, "R6 R4 orphan byte", m_rx, rxe);
    end else begin
      logic [7:0] h;
      h = mq.pop_front();
      if (h == rxe) begin
        chk(m_pass - s3 == 1, "R7 pass", m_pass - s3, 1);
        chk(m_rx == rxe, "R7 R4 R3 pass byte", m_rx, rxe);
      end else begin
        chk(m_mis - s2 == 1, "R8 mismatch", m_mis - s2, 1);
        chk(m_rx == rxe && m_exp == h, "R8 mismatch bytes",
            {m_rx, m_exp}, {rxe, h});
      end
    end
    if (cp) begin
      if (mq.size() < 8) mq.push_back(cpb);
      else mdl_ovf = 1'b1;
    end
  endtask

  task automatic check_cov();
    chk(f0 == c_f0[15:0], "R12 first0 count", f0, c_f0);
    chk(f1 == c_f1[15:0], "R12 first1 count", f1, c_f1);
    chk(l0 == c_l0[15:0], "R12 last0 count", l0, c_l0);
    chk(l1 == c_l1[15:0], "R12 last1 count", l1, c_l1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    gap = 8'd15; msb = 1'b0;
    do_reset();

    // R1: reset state and quiet idle line
    repeat (20) @(negedge clk);
    #1;
    chk({stop_err, orphan, mis, pass, ovf} == 5'b0, "R1 outputs idle",
        {stop_err, orphan, mis, pass, ovf}, 0);
    chk(rx_b == 8'h00 && f0 == 16'h0 && l1 == 16'h0, "R1 data and counters zero",
        rx_b, 0);
    chk(m_stop + m_orph + m_mis + m_pass == 0, "R1 no pulses",
        m_stop + m_orph + m_mis + m_pass, 0);

    // R6: nothing queued
    send(8'h3C, 1'b1, 15, 1'b0, 1'b0, 8'h00);
    // R7, R2: base rate, least significant bit first
    push(8'hA5);
    send(8'hA5, 1'b1, 15, 1'b0, 1'b0, 8'h00);
    // R4: reversed order, first serial bit lands in bit 7
    push(8'h80);
    send(8'h01, 1'b1, 7, 1'b1, 1'b0, 8'h00);
    // R8: mismatch still pops the head
    push(8'h11); push(8'h22);
    send(8'h33, 1'b1, 4, 1'b0, 1'b0, 8'h00);
    send(8'h22, 1'b1, 4, 1'b0, 1'b0, 8'h00);
    // R5: bad stop leaves the queue alone
    push(8'h44);
    send(8'h44, 1'b0, 9, 1'b0, 1'b0, 8'h00);
    send(8'h44, 1'b1, 9, 1'b0, 1'b0, 8'h00);
    // R11: push on the compare edge with an empty queue
    send(8'h5A, 1'b1, 6, 1'b0, 1'b1, 8'h5A);
    send(8'h5A, 1'b1, 6, 1'b0, 1'b0, 8'h00);
    chk(mq.size() == 0 && ovf == 1'b0, "R11 queue drained", ovf, 0);
    check_cov();

    // random mix, R3 gap sweep
    for (int n = 0; n < 60; n++) begin
      logic [7:0] b;
      int r, g;
      b = 8'($urandom);
      r = $urandom_range(0, 99);
      g = ($urandom_range(0, 3) == 0) ? 15 : $urandom_range(2, 20);
      if (r < 70) push(b);
      else if (r < 80) push(b ^ 8'h40);
      send(($urandom_range(0, 1) == 1) ? rev8(b) : b,
           ($urandom_range(0, 9) != 0), g, 1'b0, 1'b0, 8'h00);
    end
    chk(ovf == mdl_ovf, "R10 overflow after random", ovf, mdl_ovf);
    check_cov();

    // R10: overflow drops the ninth push and sticks
    do_reset();
    for (int i = 0; i < 9; i++) push(8'(i + 8'h60));
    #1;
    chk(ovf == 1'b1, "R10 overflow set", ovf, 1);
    for (int i = 0; i < 9; i++) send(8'(i + 8'h60), 1'b1, 3, 1'b0, 1'b0, 8'h00);
    chk(ovf == 1'b1, "R10 overflow sticky", ovf, 1);
    check_cov();

    // R10, R11: push coinciding with removal from a full queue
    do_reset();
    for (int i = 0; i < 8; i++) push(8'(i + 8'h90));
    send(8'h90, 1'b1, 3, 1'b0, 1'b1, 8'hEE);
    chk(ovf == 1'b0, "R10 full push with pop accepted", ovf, 0);
    for (int i = 1; i < 8; i++) send(8'(i + 8'h90), 1'b1, 3, 1'b0, 1'b0, 8'h00);
    send(8'hEE, 1'b1, 3, 1'b0, 1'b0, 8'h00);
    chk(ovf == 1'b0, "R10 no overflow", ovf, 0);
    check_cov();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule